// File: doc/BRIEF.md
# Dual-Plane Page Write Controller

This block manages byte writes into a nonvolatile store that is split into two equal planes, with the top address bit choosing the plane. Bytes written by the host are gathered into a page buffer. Every accepted byte restarts a load window. When the window runs out with no further write, the buffered bytes go through one internal programming cycle of fixed length. At the end of that cycle they are committed to the array together.

While programming runs, a host can poll the plane being written. On those reads, data bit 6 alternates from one read to the next, and the other bits repeat the last byte that was loaded. Reads of the other plane return array data as normal, so code can keep running from that plane. A write-control input held high refuses new writes. Raising it while a page is still loading throws the page away. A one-cycle completion event marks the end of each programming cycle and can drive an interrupt.

The defaults use a small array of two 1K-byte planes and a page of 32 bytes. A full-size part uses an address width of 13, which gives two 4K-byte planes selected by address bit 12. The load window and the programming time are parameters counted in clock cycles.

Top module: `dual_plane_pgm_ctrl`

## Requirements
- R1: The top address bit `addr[AW-1]` selects one of two planes. Bytes at the same in-plane offset in the two planes are stored independently.
- R2: The first accepted write opens a page whose tag is `addr[AW-1:5]`. Later writes with the same tag are buffered at offset `addr[4:0]`, and a later write to an offset replaces the earlier byte. A write with a different tag during loading is ignored. At commit, only the offsets that were written change in the array.
- R3: Programming starts (`busy` rises) exactly LOAD_CYCLES clock edges after the last accepted write. Each accepted write restarts this count.
- R4: Driving `wr_inhibit` high while a page is loading cancels the page. `busy` and `done` stay low, and the array keeps its old contents.
- R5: While idle, a write with `wr_inhibit` high is ignored and opens no page.
- R6: `busy` stays high for exactly PROG_CYCLES cycles. When it falls, `done` pulses for one cycle and the whole page is already readable from the array.
- R7: During programming, a read of the busy plane returns the last accepted byte with bit 6 replaced. Bit 6 is 0 on the first such read and inverts on each following one. After completion, reads of that plane return array data.
- R8: During programming, reads of the other plane return the array contents.
- R9: Writes that arrive during programming are ignored and do not reach the array.
- R10: `rdata` updates on the clock edge that samples `rd_en` and holds its value while `rd_en` is low. While a page is loading, reads return the array's old contents.
- R11: After reset, `busy`, `done` and `rdata` are 0. Reset does not clear the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | AW | Byte address; the top bit selects the plane |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe |
| wr_inhibit | input | 1 | High blocks new writes and cancels a loading page |
| rdata | output | 8 | Read data, registered |
| busy | output | 1 | Internal programming in progress |
| done | output | 1 | One-cycle pulse at the end of programming |

## Verification
A timer that restarts on the wrong write, or that does not restart at all, moves the rising edge of `busy` away from exactly LOAD_CYCLES edges after the last byte. The bench checks that edge to the cycle. A page tag or valid mask that is kept wrongly shows up only after the commit, as wrong or extra bytes when the array is read back. A toggle flop that is not cleared or not flipped shows up on the first or second poll of the busy plane. A plane compare that is wrong shows up at once: reads of the idle plane return the toggle pattern instead of array data.

// File: rtl/dual_plane_pgm_ctrl.sv
module dual_plane_pgm_ctrl #(
  parameter int AW          = 11,
  parameter int PAGE_BYTES  = 32,
  parameter int LOAD_CYCLES = 10000,
  parameter int PROG_CYCLES = 500000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          wr_inhibit,
  output logic [7:0]    rdata,
  output logic          busy,
  output logic          done
);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int TAG_W = AW - OFF_W;
  localparam int LCW   = $clog2(LOAD_CYCLES + 1);
  localparam int PCW   = $clog2(PROG_CYCLES + 1);
  localparam int DEPTH = 1 << AW;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_PROG} state_t;

  state_t                  state;
  logic [LCW-1:0]          load_cnt;
  logic [PCW-1:0]          prog_cnt;
  logic [TAG_W-1:0]        ptag;
  logic [PAGE_BYTES-1:0]   pvalid;
  logic [7:0]              pbuf [PAGE_BYTES];
  logic [7:0]              lastb;
  logic                    tog;
  logic [7:0]              mem [DEPTH];

  wire [TAG_W-1:0] in_tag  = addr[AW-1:OFF_W];
  wire [OFF_W-1:0] in_off  = addr[OFF_W-1:0];
  wire             wr_ok   = wr_en && !wr_inhibit;
  wire             open_pg = (state == S_IDLE) && wr_ok;
  wire             add_pg  = (state == S_LOAD) && wr_ok && (in_tag == ptag);
  wire             accept  = open_pg || add_pg;
  wire             cancel  = (state == S_LOAD) && wr_inhibit;
  wire             commit  = (state == S_PROG) && (prog_cnt == '0);
  wire             poll    = rd_en && (state == S_PROG) && (addr[AW-1] == ptag[TAG_W-1]);

  assign busy = (state == S_PROG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      load_cnt <= '0;
      prog_cnt <= '0;
      ptag     <= '0;
      pvalid   <= '0;
      lastb    <= '0;
      tog      <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (open_pg) begin
          state    <= S_LOAD;
          ptag     <= in_tag;
          pvalid   <= '0;
          pvalid[in_off] <= 1'b1;
          lastb    <= wdata;
          load_cnt <= LCW'(LOAD_CYCLES - 1);
        end
        S_LOAD: if (cancel) begin
          state <= S_IDLE;
        end else if (add_pg) begin
          pvalid[in_off] <= 1'b1;
          lastb    <= wdata;
          load_cnt <= LCW'(LOAD_CYCLES - 1);
        end else if (load_cnt == '0) begin
          state    <= S_PROG;
          prog_cnt <= PCW'(PROG_CYCLES - 1);
          tog      <= 1'b0;
        end else begin
          load_cnt <= load_cnt - 1'b1;
        end
        S_PROG: begin
          if (poll) tog <= ~tog;
          if (commit) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end else begin
            prog_cnt <= prog_cnt - 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (accept) pbuf[in_off] <= wdata;
    if (commit)
      for (int i = 0; i < PAGE_BYTES; i++)
        if (pvalid[i]) mem[{ptag, OFF_W'(i)}] <= pbuf[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else if (poll) rdata <= {lastb[7], tog, lastb[5:0]};
    else if (rd_en) rdata <= mem[addr];
  end

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R6
  AST_IDLE_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && wr_inhibit) |=> (state == S_IDLE)); // R5
  AST_CANCEL_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LOAD && wr_inhibit) |=> (state == S_IDLE && !busy)); // R4
  AST_OPEN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && wr_en && !wr_inhibit) |=> (state == S_LOAD && $countones(pvalid) == 1)); // R2
  AST_PROG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PROG && wr_en) |=> ($stable(pvalid) && $stable(ptag) && $stable(lastb))); // R9
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R10
endmodule

// File: tb/dual_plane_pgm_ctrl_tb.sv
module dual_plane_pgm_ctrl_tb;
  localparam int AW = 11;
  localparam int L  = 20;
  localparam int P  = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic wr_en = 1'b0, rd_en = 1'b0, wr_inhibit = 1'b0;
  logic [7:0] rdata;
  logic busy, done;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  dual_plane_pgm_ctrl #(.AW(AW), .PAGE_BYTES(32), .LOAD_CYCLES(L), .PROG_CYCLES(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .wr_inhibit(wr_inhibit), .rdata(rdata), .busy(busy), .done(done));

  function automatic logic [AW-1:0] ad(input logic pl, input int pg, input int off);
    return {pl, 5'(pg), 5'(off)};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Called right after the last accepted write: checks load window, busy length, done.
  task automatic finish_page(input string tag);
    int bc;
    idle(L - 1);
    chk(busy == 1'b0, {"R3 busy early ", tag}, busy, 0);
    idle(1);
    chk(busy == 1'b1, {"R3 busy start ", tag}, busy, 1);
    bc = 1;
    while (busy && bc < P + 5) begin idle(1); if (busy) bc++; end
    chk(bc == P, {"R6 busy length ", tag}, bc, P);
    chk(done == 1'b1, {"R6 done pulse ", tag}, done, 1);
    idle(1);
    chk(done == 1'b0, {"R6 done width ", tag}, done, 0);
  endtask

  task automatic t_reset;
    chk(busy == 0, "R11 busy", busy, 0);
    chk(done == 0, "R11 done", done, 0);
    chk(rdata == 0, "R11 rdata", rdata, 0);
  endtask

  task automatic t_basic;
    logic [7:0] d;
    wr(ad(0, 0, 0), 8'h11);
    wr(ad(0, 0, 1), 8'h22);
    wr(ad(0, 0, 31), 8'h33);
    wr(ad(0, 0, 1), 8'h24);
    finish_page("basic");
    rd(ad(0, 0, 0), d);  chk(d == 8'h11, "R2 off0", d, 8'h11);
    rd(ad(0, 0, 1), d);  chk(d == 8'h24, "R2 overwrite", d, 8'h24);
    rd(ad(0, 0, 31), d); chk(d == 8'h33, "R2 off31", d, 8'h33);
    wr(ad(1, 0, 0), 8'h99);
    finish_page("plane1");
    rd(ad(1, 0, 0), d); chk(d == 8'h99, "R1 plane1", d, 8'h99);
    rd(ad(0, 0, 0), d); chk(d == 8'h11, "R1 plane0 kept", d, 8'h11);
    idle(3);
    chk(rdata == 8'h11, "R10 hold", rdata, 8'h11);
  endtask

  task automatic t_restart_and_page;
    logic [7:0] d;
    wr(ad(0, 3, 4), 8'hA0);
    finish_page("pre");
    wr(ad(0, 2, 4), 8'h01);
    idle(L - 3);
    chk(busy == 0, "R3 before restart", busy, 0);
    wr(ad(0, 2, 5), 8'h02);
    wr(ad(0, 3, 4), 8'hEE);
    rd(ad(0, 2, 4), d);
    chk(busy == 0, "R3 restart no busy", busy, 0);
    // window restarted by the 0x02 write; ignored write and read took 4 edges
    idle(L - 5);
    chk(busy == 0, "R3 restart early", busy, 0);
    idle(1);
    chk(busy == 1, "R3 restart start", busy, 1);
    while (busy) idle(1);
    idle(1);
    rd(ad(0, 2, 5), d); chk(d == 8'h02, "R2 second byte", d, 8'h02);
    rd(ad(0, 3, 4), d); chk(d == 8'hA0, "R2 out of page ignored", d, 8'hA0);
  endtask

  task automatic t_poll;
    logic [7:0] d;
    wr(ad(0, 5, 7), 8'h3C);
    finish_page("other");
    wr(ad(1, 6, 0), 8'h10);
    wr(ad(1, 6, 2), 8'hC3);
    idle(L);
    chk(busy == 1, "R3 poll busy", busy, 1);
    rd(ad(1, 6, 0), d); chk(d == 8'h83, "R7 poll first", d, 8'h83);
    rd(ad(1, 9, 9), d); chk(d == 8'hC3, "R7 poll second", d, 8'hC3);
    rd(ad(0, 5, 7), d); chk(d == 8'h3C, "R8 other plane", d, 8'h3C);
    rd(ad(1, 6, 2), d); chk(d == 8'h83, "R7 poll third", d, 8'h83);
    wr(ad(0, 5, 7), 8'h77);
    while (busy) idle(1);
    idle(1);
    rd(ad(1, 6, 2), d); chk(d == 8'hC3, "R7 after done", d, 8'hC3);
    rd(ad(1, 6, 0), d); chk(d == 8'h10, "R7 after done b0", d, 8'h10);
    rd(ad(0, 5, 7), d); chk(d == 8'h3C, "R9 write during prog", d, 8'h3C);
    idle(L + 2);
    chk(busy == 0, "R9 no new page", busy, 0);
  endtask

  task automatic t_cancel_inhibit;
    logic [7:0] d;
    bit seen = 0;
    wr(ad(0, 8, 1), 8'h5A);
    rd(ad(0, 8, 1), d);
    chk(d == 8'h00 || d == 8'h5A ? d != 8'h5A : 1'b0, "R10 read during load", d, 0);
    @(negedge clk); wr_inhibit = 1'b1;
    @(negedge clk); wr_inhibit = 1'b0;
    for (int i = 0; i < L + P + 4; i++) begin idle(1); if (busy || done) seen = 1; end
    chk(!seen, "R4 cancel no busy", seen, 0);
    wr(ad(0, 8, 1), 8'h61);
    finish_page("setup");
    wr_inhibit = 1'b1;
    wr(ad(0, 8, 1), 8'h62);
    seen = 0;
    for (int i = 0; i < L + 4; i++) begin idle(1); if (busy) seen = 1; end
    wr_inhibit = 1'b0;
    chk(!seen, "R5 inhibit idle busy", seen, 0);
    rd(ad(0, 8, 1), d); chk(d == 8'h61, "R5 inhibit idle data", d, 8'h61);
    wr(ad(0, 8, 1), 8'h63);
    @(negedge clk); wr_inhibit = 1'b1;
    @(negedge clk); wr_inhibit = 1'b0;
    idle(L + P + 4);
    rd(ad(0, 8, 1), d); chk(d == 8'h61, "R4 cancel keeps array", d, 8'h61);
  endtask

  initial begin
    fork
      begin
        idle(3); rst_n = 1'b1; idle(1);
        t_reset();
        t_basic();
        t_restart_and_page();
        t_poll();
        t_cancel_inhibit();
        rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(1);
        t_reset();
      end
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule